// File: doc/BRIEF.md
# Warp Same-Address Write Serializer

This block takes one memory request covering every lane of a 32-lane warp and applies it to a small internal word memory. Each lane carries a word address, a data word and an active flag. One opcode bit selects the whole request's operation: an atomic add or a plain store.

For atomic adds, the block applies the add of every active lane as its own read-modify-write, one per cycle, in ascending lane order. Lanes that share an address therefore accumulate, and no update is lost. For plain stores, each distinct address receives exactly one write, and the highest-indexed active lane aiming at that address supplies the value. Lanes whose store is overwritten inside the same request cost no cycle.

A request enters on a valid/ready handshake. While a request is in progress, no other request is taken. Completion is reported on a second valid/ready pair. A combinational read port shows any memory word, so results can be inspected between requests.

Top module: `warp_write_serializer`

## Requirements
- R1: After reset, req_ready is 1, done_valid is 0 and every one of the 64 memory words reads 0.
- R2: In an atomic request (req_atomic=1), every active lane adds its 32-bit data to the word it addresses, so N active lanes adding 1 to one word raise it by exactly N.
- R3: In a store request (req_atomic=0), each word addressed by at least one active lane ends up holding the data of the highest-indexed active lane addressing it.
- R4: A lane whose bit in req_active is 0 changes no memory word, and a request with no active lane changes nothing.
- R5: Only the low 6 bits of each lane's 8-bit address are used, so addresses wrap modulo 64.
- R6: req_ready is 0 from the cycle after a request is accepted until completion is acknowledged; a request offered meanwhile is neither taken nor applied.
- R7: done_valid rises exactly W clock edges after the accepting edge, where W is the number of active lanes for an atomic request, the number of distinct active addresses for a store request, and 1 when that count is 0.
- R8: done_valid stays 1 until a clock edge with done_ready=1, after which done_valid is 0 and req_ready is 1.
- R9: Atomic sums wrap modulo 2^32.
- R10: rd_data shows the memory word selected by rd_addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; a request is accepted on an edge where both are 1 |
| req_atomic | input | 1 | 1 = atomic add, 0 = plain store |
| req_active | input | 32 | Active flag per lane, bit i = lane i |
| req_addr | input | 256 | Lane i word address in bits [8i+7:8i] |
| req_data | input | 1024 | Lane i data in bits [32i+31:32i] |
| done_valid | output | 1 | Request finished |
| done_ready | input | 1 | Completion acknowledged |
| rd_addr | input | 6 | Read port word address |
| rd_data | output | 32 | Read port word |

## Verification
The main function is driven with several patterns. In one, every lane adds 1 to a single word; this separates true serialization from a lost-update merge. Four lanes cycle over store addresses to show which lane wins. Half a warp stores to one word, which tests the tie-break together with masking. Odd lanes only add across the wrap point. A stride of eight folds the upper address bits. Only the two edge lanes take part in one request. The cycle count to completion tells apart designs that skip superseded stores and idle lanes from ones that walk every lane. Directed cases then cover an empty mask, a carry out of 32 bits, a request held against the busy block, and a delayed acknowledge.

// File: rtl/wws_pkg.sv
package wws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } state_e;
endpackage

// File: rtl/wws_conflict.sv
// Marks, per lane, whether its store survives: active and not overwritten
// by a higher-indexed active lane at the same word address.
module wws_conflict #(
    parameter int LANES = 32,
    parameter int AW    = 6
) (
    input  logic [LANES-1:0]    active,
    input  logic [LANES*AW-1:0] addr,
    output logic [LANES-1:0]    keep
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int j = i + 1; j < LANES; j++) begin
                if (active[j] && (addr[j*AW +: AW] == addr[i*AW +: AW])) begin
                    hit = 1'b1;
                end
            end
        end
        assign keep[i] = active[i] & ~hit;
    end
endmodule

// File: rtl/wws_pick.sv
// Lowest-index set bit of a pending mask.
module wws_pick #(
    parameter int LANES = 32,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [LANES-1:0] mask,
    output logic [LW-1:0]    idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = |mask;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = LW'(i);
            end
        end
    end
endmodule

// File: rtl/wws_mem.sv
// Word memory: one write port, two combinational read ports, cleared on reset.
module wws_mem #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata_a = words[raddr_a];
    assign rdata_b = words[raddr_b];
endmodule

// File: rtl/warp_write_serializer.sv
module warp_write_serializer
    import wws_pkg::*;
#(
    parameter int LANES = 32,
    parameter int IAW   = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_atomic,
    input  logic [LANES-1:0]    req_active,
    input  logic [LANES*IAW-1:0] req_addr,
    input  logic [LANES*DW-1:0] req_data,
    output logic                done_valid,
    input  logic                done_ready,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data
);
    typedef struct packed {
        state_e                state;
        logic                  atomic;
        logic [LANES-1:0]      pending;
        logic [LANES*AW-1:0]   addr;
        logic [LANES*DW-1:0]   data;
    } regs_t;

    regs_t q, d;

    // Word index per lane: low AW bits of the incoming address.
    logic [LANES*AW-1:0] in_addr;
    for (genvar i = 0; i < LANES; i++) begin : g_trunc
        assign in_addr[i*AW +: AW] = req_addr[i*IAW +: AW];
    end

    logic [LANES-1:0] keep;
    wws_conflict #(.LANES(LANES), .AW(AW)) u_conflict (
        .active (req_active),
        .addr   (in_addr),
        .keep   (keep)
    );

    logic [LW-1:0] pick_idx;
    logic          pick_any;
    wws_pick #(.LANES(LANES)) u_pick (
        .mask (q.pending),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_data;
    logic [DW-1:0] old_word;
    logic [DW-1:0] new_word;
    logic          mem_we;

    assign cur_addr = q.addr[pick_idx*AW +: AW];
    assign cur_data = q.data[pick_idx*DW +: DW];
    assign new_word = q.atomic ? (old_word + cur_data) : cur_data;
    assign mem_we   = (q.state == ST_BUSY) && pick_any;

    wws_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (cur_addr),
        .wdata   (new_word),
        .raddr_a (cur_addr),
        .rdata_a (old_word),
        .raddr_b (rd_addr),
        .rdata_b (rd_data)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state   = ST_BUSY;
                    d.atomic  = req_atomic;
                    d.addr    = in_addr;
                    d.data    = req_data;
                    d.pending = req_atomic ? req_active : keep;
                end
            end
            ST_BUSY: begin
                if (pick_any) begin
                    d.pending[pick_idx] = 1'b0;
                    if (d.pending == '0) begin
                        d.state = ST_DONE;
                    end
                end else begin
                    d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                if (done_ready) begin
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.state == ST_IDLE);
    assign done_valid = (q.state == ST_DONE);
endmodule

// File: rtl/wws_checker.sv
module wws_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done_valid,
    input logic done_ready
);
    // R1/R8: never idle and finished at once
    a_r1_exclusive_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, done_valid}));

    // R6: an accepted request closes the request side at once
    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !done_valid));

    // R8: completion holds until acknowledged
    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_ready) |=> done_valid);

    // R8: acknowledge returns to idle
    a_r8_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_ready) |=> (req_ready && !done_valid));

    // R6: the request side reopens only through completion
    a_r6_ready_via_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> $past(done_valid));
endmodule

bind warp_write_serializer wws_checker u_wws_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .done_valid (done_valid),
    .done_ready (done_ready)
);

// File: tb/tb_warp_write_serializer.sv
module tb_warp_write_serializer;
    localparam int LANES = 32;
    localparam int IAW   = 8;
    localparam int DW    = 32;
    localparam int DEPTH = 64;
    localparam int AW    = 6;

    typedef struct packed {
        logic        atomic;
        logic [31:0] mask;
        logic [1:0]  amode;   // 0 same, 1 base+lane%4, 2 base+lane, 3 base+8*lane
        logic [7:0]  base;
        logic [31:0] dseed;
        logic [7:0]  dstep;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{atomic:1'b1, mask:32'hFFFF_FFFF, amode:2'd0, base:8'd5,   dseed:32'd1,      dstep:8'd0}, // R2
        '{atomic:1'b0, mask:32'hFFFF_FFFF, amode:2'd1, base:8'd10,  dseed:32'h100,    dstep:8'd1}, // R3
        '{atomic:1'b0, mask:32'h0000_FFFF, amode:2'd0, base:8'd20,  dseed:32'hA0,     dstep:8'd1}, // R3 R4
        '{atomic:1'b1, mask:32'hAAAA_AAAA, amode:2'd2, base:8'd40,  dseed:32'h1000,   dstep:8'd3}, // R4 R5
        '{atomic:1'b0, mask:32'hFFFF_FFFF, amode:2'd3, base:8'hC3,  dseed:32'h5500,   dstep:8'd7}, // R5
        '{atomic:1'b1, mask:32'h8000_0001, amode:2'd1, base:8'd5,   dseed:32'd7,      dstep:8'd0}  // R2
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic                 req_atomic = 1'b0;
    logic [LANES-1:0]     req_active = '0;
    logic [LANES*IAW-1:0] req_addr = '0;
    logic [LANES*DW-1:0]  req_data = '0;
    logic                 done_valid;
    logic                 done_ready = 1'b0;
    logic [AW-1:0]        rd_addr = '0;
    logic [DW-1:0]        rd_data;

    always #5 clk = ~clk;

    warp_write_serializer dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_atomic(req_atomic), .req_active(req_active),
        .req_addr(req_addr), .req_data(req_data),
        .done_valid(done_valid), .done_ready(done_ready),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int ntot = 0;
    int nbad = 0;
    bit finished = 0;
    logic [31:0] model [DEPTH];

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        ntot++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] lane_addr(vec_t v, int i);
        case (v.amode)
            2'd0: return v.base;
            2'd1: return v.base + 8'(i % 4);
            2'd2: return v.base + 8'(i);
            default: return v.base + 8'(i * 8);
        endcase
    endfunction

    // R10: memory read through the combinational read port
    task automatic compare_mem(string req);
        logic [31:0] act = '0, exp = '0;
        bit ok = 1;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a);
            #1;
            if (ok && rd_data !== model[a]) begin
                ok = 0; act = rd_data; exp = model[a];
                $display("mismatch at word %0d", a);
            end
        end
        check(ok, req, act, exp);
    endtask

    task automatic run_vec(vec_t v, bit intrude, int hold, string req);
        bit seen [DEPTH];
        int w = 0;
        int cyc = 0;
        bit busy_ok = 1;
        bit hold_ok = 1;
        for (int a = 0; a < DEPTH; a++) seen[a] = 0;
        for (int i = 0; i < LANES; i++) begin
            logic [7:0]  ad = lane_addr(v, i);
            logic [31:0] dt = v.dseed + 32'(i) * 32'(v.dstep);
            req_addr[i*IAW +: IAW] = ad;
            req_data[i*DW +: DW]   = dt;
            if (v.mask[i]) begin
                if (v.atomic) begin
                    model[ad[5:0]] = model[ad[5:0]] + dt;
                    w++;
                end else begin
                    model[ad[5:0]] = dt;
                    if (!seen[ad[5:0]]) w++;
                    seen[ad[5:0]] = 1;
                end
            end
        end
        if (w == 0) w = 1;
        req_atomic = v.atomic;
        req_active = v.mask;
        req_valid  = 1'b1;
        check(req_ready === 1'b1, "R6 ready before offer", 32'(req_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = intrude;
        if (intrude) begin
            req_atomic = 1'b1;
            req_active = '1;
            for (int i = 0; i < LANES; i++) begin
                req_addr[i*IAW +: IAW] = 8'd63;
                req_data[i*DW +: DW]   = 32'h100;
            end
        end
        while (!done_valid && cyc < 200) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        if (intrude) check(busy_ok, "R6 ready low while busy", 32'(busy_ok), 32'd1);
        check(cyc == w, {req, " R7 latency"}, 32'(cyc), 32'(w));
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            if (!done_valid || req_ready) hold_ok = 0;
        end
        if (hold > 0) check(hold_ok, "R8 done held", 32'(hold_ok), 32'd1);
        done_ready = 1'b1;
        @(negedge clk);
        done_ready = 1'b0;
        check(req_ready && !done_valid, "R8 idle after ack",
              {30'd0, req_ready, done_valid}, 32'd2);
        compare_mem({req, " memory"});
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            finished = 1;
            ntot++; nbad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("test done: total=%0d bad=%0d", ntot, nbad);
            $finish;
        end
    end

    initial begin
        vec_t v;
        for (int a = 0; a < DEPTH; a++) model[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready === 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
        check(done_valid === 1'b0, "R1 done_valid", 32'(done_valid), 32'd0);
        compare_mem("R1 cleared memory");

        // Table walk
        for (int n = 0; n < NV; n++) begin
            run_vec(VECS[n], 1'b0, 0, $sformatf("vec%0d R2 R3 R4 R5", n));
        end

        // R4: empty mask changes nothing, one cycle
        v = '{atomic:1'b1, mask:32'h0, amode:2'd0, base:8'd5, dseed:32'hDEAD, dstep:8'd1};
        run_vec(v, 1'b0, 0, "R4 empty mask");

        // R9: carry out of 32 bits wraps
        v = '{atomic:1'b1, mask:32'h3, amode:2'd0, base:8'd50, dseed:32'hFFFF_FFFF, dstep:8'd0};
        run_vec(v, 1'b0, 0, "R9 wrap");
        check(model[50] == 32'hFFFF_FFFE, "R9 model", model[50], 32'hFFFF_FFFE);

        // R6: request held against a busy block is not taken
        v = '{atomic:1'b1, mask:32'h0000_00FF, amode:2'd2, base:8'd30, dseed:32'd9, dstep:8'd2};
        run_vec(v, 1'b1, 0, "R6 intrusion");

        // R8: delayed acknowledge, store with tie on one word
        v = '{atomic:1'b0, mask:32'hF000_000F, amode:2'd0, base:8'd61, dseed:32'h77, dstep:8'd5};
        run_vec(v, 1'b0, 4, "R8 hold R3");

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", ntot, nbad);
            $finish;
        end
    end
endmodule